// File: doc/BRIEF.md
# Command Phase Handshake Sequencer

This block runs the host side of the command phase of a disk-controller command engine. It drives two bits of a main status word. The ready bit (`rqm`) says that the block will take the next byte. The direction bit (`dio`) says which way that byte moves: 0 means host to block, 1 means block to host. The host writes an opcode byte and then the number of parameter bytes that opcode needs. The block withdraws `rqm` after every accepted byte and holds it low while the byte is processed. It re-arms `rqm` for each further parameter.

When the last byte has arrived, the block pulses `cmd_valid` with every collected byte and the byte count. It then stays in the execution phase with `rqm` low until the downstream engine signals `exec_done`. An opcode outside the table is not handed downstream. Instead the block raises `cmd_invalid`, turns the bus around (`dio=1`) and offers one result byte. Once the host reads that byte, the block returns to the command phase. The data FIFO enable is held off everywhere except in the execution phase.

Top module: `cmd_handshake_seq`

## Requirements
- R1: After reset, `rqm=1`, `dio=0`, `fifo_en=0`, `cmd_valid=0`, `cmd_invalid=0` and `host_rdata=0`. The block waits for an opcode.
- R2: A host write is accepted only while `rqm=1` and `dio=0`. A write at any other time changes neither the collected bytes, nor the byte count, nor the phase timing.
- R3: `rqm` is 0 in the two cycles that follow the clock edge that accepts a host write or read. It returns to 1 on the second edge after that acceptance, unless the command is complete.
- R4: The legal opcodes and their parameter counts are: 0x08 takes 0; 0x04, 0x07 and 0x0A take 1; 0x03 and 0x0F take 2; 0x13 takes 3; 0x0D takes 5; 0x05 and 0x06 take 8.
- R5: On the second edge after the final byte is accepted, `cmd_valid` is high for exactly one cycle. At that point `cmd_nbytes` equals 1 plus the parameter count. Byte k, in arrival order with the opcode as k=0, sits at `cmd_bytes[8k+7:8k]`. `rqm` stays 0 after the pulse.
- R6: `fifo_en` is 0 throughout the command and result phases. It is 1 from the `cmd_valid` cycle until the execution phase ends.
- R7: An opcode outside the table never pulses `cmd_valid`. Two edges after it is accepted, the block shows `cmd_invalid=1`, `dio=1`, `rqm=1` and `host_rdata=0x80`.
- R8: A `host_rd` while `rqm=1` and `dio=1` consumes the result byte. The R3 timing then applies, and the block ends with `rqm=1`, `dio=0` and `cmd_invalid=0`. A `host_rd` at any other time is ignored.
- R9: `exec_done` during the execution phase returns the block to the command phase on the next edge, with `rqm=1` and `fifo_en=0`. At any other time `exec_done` is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_wr | input | 1 | Host byte write strobe, one cycle per byte |
| host_rd | input | 1 | Host result byte read strobe |
| host_wdata | input | 8 | Host write byte |
| host_rdata | output | 8 | Result byte (0x80 while an invalid command is pending, else 0) |
| rqm | output | 1 | Status: block ready for a byte transfer |
| dio | output | 1 | Status: transfer direction, 1 = block to host |
| exec_done | input | 1 | Execution engine finished, return to command phase |
| cmd_valid | output | 1 | One-cycle pulse: a complete command is ready |
| cmd_invalid | output | 1 | Unrecognised opcode is pending |
| cmd_nbytes | output | 4 | Number of bytes collected for the command |
| cmd_bytes | output | 72 | Collected bytes, byte k at bits [8k+7:8k] |
| fifo_en | output | 1 | Data FIFO enable, high only in the execution phase |

## Verification
Every result is registered, so it is due a fixed number of edges after the edge that samples its stimulus. `rqm` falls one edge after an accepted strobe. `rqm` re-arms, `cmd_valid` pulses, and `cmd_invalid`/`dio` rise on the second edge after it. `exec_done` takes effect one edge later. The bench drives each strobe for exactly one cycle between falling edges and samples only at falling edges. After every strobe it checks `rqm` at the first and second falling edges and the final outcome at the third. Ignored stimuli are applied inside these windows, and the expected timing and byte contents are then confirmed unchanged.

// File: rtl/cmdseq_pkg.sv
// Package for the command phase sequencer.
// Holds the controller state encoding, the opcode information record and the
// opcode table lookup. Assumes byte-wide host transfers.
package cmdseq_pkg;

    localparam int BYTE_W      = 8;
    localparam int INFO_CNT_W  = 4;

    typedef enum logic [2:0] {
        ST_IDLE       = 3'd0,
        ST_OPC_WAIT   = 3'd1,
        ST_PARAM      = 3'd2,
        ST_PARAM_WAIT = 3'd3,
        ST_EXEC       = 3'd4,
        ST_RES        = 3'd5,
        ST_RES_WAIT   = 3'd6
    } seq_state_t;

    typedef struct packed {
        logic                  legal;
        logic [INFO_CNT_W-1:0] nparams;
    } op_info_t;

    // Map an opcode byte to its legality and parameter byte count.
    function automatic op_info_t lookup_opcode(input logic [BYTE_W-1:0] op);
        op_info_t info;
        info.legal   = 1'b1;
        info.nparams = '0;
        case (op)
            8'h08:               info.nparams = 4'd0;
            8'h04, 8'h07, 8'h0A: info.nparams = 4'd1;
            8'h03, 8'h0F:        info.nparams = 4'd2;
            8'h13:               info.nparams = 4'd3;
            8'h0D:               info.nparams = 4'd5;
            8'h05, 8'h06:        info.nparams = 4'd8;
            default:             info.legal   = 1'b0;
        endcase
        return info;
    endfunction

endpackage

// File: rtl/cmdseq_opdec.sv
// Opcode decoder.
// Purely combinational: turns the stored opcode into a legal flag and a
// parameter count. Assumes the opcode input is stable while it is consulted.
// Table entries needing more than MAX_PARAMS bytes are reported illegal.
module cmdseq_opdec #(
    parameter int MAX_PARAMS = 8,
    localparam int CNT_W     = $clog2(MAX_PARAMS + 2)
) (
    input  logic [7:0]       opcode,
    output logic             op_legal,
    output logic [CNT_W-1:0] op_nparams
);
    import cmdseq_pkg::*;

    op_info_t info;

    // Look up the opcode and clip the table against the collector depth.
    always_comb begin
        info       = lookup_opcode(opcode);
        op_legal   = info.legal && (int'(info.nparams) <= MAX_PARAMS);
        op_nparams = CNT_W'(info.nparams);
    end

endmodule

// File: rtl/cmdseq_pacer.sv
// Byte processing pacer.
// Counts a fixed PROC_CYCLES-cycle processing window after each accepted
// host transfer. `done` is high in the last cycle of the window, so the
// controller acts on the following edge. Assumes start never arrives while busy.
module cmdseq_pacer #(
    parameter int PROC_CYCLES = 2,
    localparam int CW         = $clog2(PROC_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);
    logic [CW-1:0] cnt;

    assign done = busy && (cnt == '0);

    // Load the window on start, count it down, and release at the end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
        end else if (start) begin
            busy <= 1'b1;
            cnt  <= CW'(PROC_CYCLES - 1);
        end else if (done) begin
            busy <= 1'b0;
        end else if (busy) begin
            cnt <= cnt - 1'b1;
        end
    end

    assert_pace_start_R3: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy)
        else $error("pacer did not enter its window");

endmodule

// File: rtl/cmdseq_collect.sv
// Command byte collector.
// Holds one register per command byte slot. `clear` empties every slot,
// except the slot being loaded in the same cycle. Assumes idx < SLOTS
// whenever load is high.
module cmdseq_collect #(
    parameter int SLOTS  = 9,
    parameter int BYTE_W = 8,
    localparam int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    clear,
    input  logic                    load,
    input  logic [CNT_W-1:0]        idx,
    input  logic [BYTE_W-1:0]       din,
    output logic [SLOTS*BYTE_W-1:0] bytes_o
);
    for (genvar i = 0; i < SLOTS; i++) begin : g_slot
        logic [BYTE_W-1:0] slot_q;

        // Capture the incoming byte into its slot, or empty it on a new command.
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot_q <= '0;
            else if (load && (idx == CNT_W'(i)))
                slot_q <= din;
            else if (clear)
                slot_q <= '0;
        end

        assign bytes_o[i*BYTE_W +: BYTE_W] = slot_q;
    end

    assert_quiet_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !(load || clear) |=> $stable(bytes_o))
        else $error("collected bytes changed without a load");

endmodule

// File: rtl/cmdseq_ctrl.sv
// Command phase controller.
// Sequences command, execution and result phases, and drives the ready and
// direction status bits from its state. It decides acceptance of host
// strobes, addresses the collector and starts the pacer. Assumes the opcode
// decode reflects collector slot 0.
module cmdseq_ctrl #(
    parameter int MAX_PARAMS = 8,
    localparam int CNT_W     = $clog2(MAX_PARAMS + 2)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_wr,
    input  logic             host_rd,
    input  logic             exec_done,
    input  logic             op_legal,
    input  logic [CNT_W-1:0] op_nparams,
    input  logic             pace_busy,
    input  logic             pace_done,
    output logic             pace_start,
    output logic             col_clear,
    output logic             col_load,
    output logic [CNT_W-1:0] col_idx,
    output logic             rqm,
    output logic             dio,
    output logic             fifo_en,
    output logic             invalid,
    output logic             cmd_valid,
    output logic [CNT_W-1:0] nbytes
);
    import cmdseq_pkg::*;

    seq_state_t       state;
    logic [CNT_W-1:0] rcvd;
    logic [CNT_W-1:0] need;
    logic             accept_wr;
    logic             accept_rd;

    // Status bits and data path enables decoded from the phase.
    always_comb begin
        rqm       = (state == ST_IDLE) || (state == ST_PARAM) || (state == ST_RES);
        dio       = (state == ST_RES) || (state == ST_RES_WAIT);
        fifo_en   = (state == ST_EXEC);
        invalid   = dio;
        accept_wr = host_wr && ((state == ST_IDLE) || (state == ST_PARAM));
        accept_rd = host_rd && (state == ST_RES);
    end

    // Collector and pacer requests for an accepted transfer.
    always_comb begin
        pace_start = accept_wr || accept_rd;
        col_load   = accept_wr;
        col_clear  = accept_wr && (state == ST_IDLE);
        col_idx    = (state == ST_IDLE) ? '0 : rcvd;
    end

    assign nbytes = rcvd;

    // Phase sequencing, byte counting and the command-ready pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            rcvd      <= '0;
            need      <= '0;
            cmd_valid <= 1'b0;
        end else begin
            cmd_valid <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (host_wr) begin
                        rcvd  <= CNT_W'(1);
                        state <= ST_OPC_WAIT;
                    end
                end
                ST_OPC_WAIT: begin
                    if (pace_done) begin
                        if (!op_legal) begin
                            state <= ST_RES;
                        end else if (op_nparams == '0) begin
                            state     <= ST_EXEC;
                            cmd_valid <= 1'b1;
                        end else begin
                            need  <= op_nparams;
                            state <= ST_PARAM;
                        end
                    end
                end
                ST_PARAM: begin
                    if (host_wr) begin
                        rcvd  <= rcvd + CNT_W'(1);
                        state <= ST_PARAM_WAIT;
                    end
                end
                ST_PARAM_WAIT: begin
                    if (pace_done) begin
                        if (rcvd == need + CNT_W'(1)) begin
                            state     <= ST_EXEC;
                            cmd_valid <= 1'b1;
                        end else begin
                            state <= ST_PARAM;
                        end
                    end
                end
                ST_EXEC: begin
                    if (exec_done)
                        state <= ST_IDLE;
                end
                ST_RES: begin
                    if (host_rd)
                        state <= ST_RES_WAIT;
                end
                ST_RES_WAIT: begin
                    if (pace_done)
                        state <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assert_ack_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        accept_wr |=> !rqm)
        else $error("ready bit not withdrawn after a write");

    assert_hold_low_R3: assert property (@(posedge clk) disable iff (!rst_n)
        pace_busy |-> !rqm)
        else $error("ready bit raised inside the processing window");

    assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid)
        else $error("command-ready pulse longer than one cycle");

    assert_done_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> !rqm)
        else $error("ready bit high at command hand-off");

endmodule

// File: rtl/cmd_handshake_seq.sv
// Command phase handshake sequencer, top level.
// Wires the controller, pacer, collector and opcode decoder together, and
// drives the single result byte offered for an unrecognised opcode.
// Assumes one host strobe per cycle at most.
module cmd_handshake_seq #(
    parameter int MAX_PARAMS    = 8,
    parameter int PROC_CYCLES   = 2,
    parameter logic [7:0] RESULT_CODE = 8'h80,
    localparam int SLOTS        = MAX_PARAMS + 1,
    localparam int CNT_W        = $clog2(SLOTS + 1),
    localparam int BYTE_W       = cmdseq_pkg::BYTE_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    host_wr,
    input  logic                    host_rd,
    input  logic [BYTE_W-1:0]       host_wdata,
    output logic [BYTE_W-1:0]       host_rdata,
    output logic                    rqm,
    output logic                    dio,
    input  logic                    exec_done,
    output logic                    cmd_valid,
    output logic                    cmd_invalid,
    output logic [CNT_W-1:0]        cmd_nbytes,
    output logic [SLOTS*BYTE_W-1:0] cmd_bytes,
    output logic                    fifo_en
);
    logic             op_legal;
    logic [CNT_W-1:0] op_nparams;
    logic             pace_start;
    logic             pace_busy;
    logic             pace_done;
    logic             col_clear;
    logic             col_load;
    logic [CNT_W-1:0] col_idx;

    cmdseq_ctrl #(.MAX_PARAMS(MAX_PARAMS)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .exec_done  (exec_done),
        .op_legal   (op_legal),
        .op_nparams (op_nparams),
        .pace_busy  (pace_busy),
        .pace_done  (pace_done),
        .pace_start (pace_start),
        .col_clear  (col_clear),
        .col_load   (col_load),
        .col_idx    (col_idx),
        .rqm        (rqm),
        .dio        (dio),
        .fifo_en    (fifo_en),
        .invalid    (cmd_invalid),
        .cmd_valid  (cmd_valid),
        .nbytes     (cmd_nbytes)
    );

    cmdseq_pacer #(.PROC_CYCLES(PROC_CYCLES)) u_pacer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pace_start),
        .busy  (pace_busy),
        .done  (pace_done)
    );

    cmdseq_collect #(.SLOTS(SLOTS), .BYTE_W(BYTE_W)) u_collect (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (col_clear),
        .load    (col_load),
        .idx     (col_idx),
        .din     (host_wdata),
        .bytes_o (cmd_bytes)
    );

    cmdseq_opdec #(.MAX_PARAMS(MAX_PARAMS)) u_opdec (
        .opcode     (cmd_bytes[BYTE_W-1:0]),
        .op_legal   (op_legal),
        .op_nparams (op_nparams)
    );

    // Result byte offered to the host while an invalid command is pending.
    assign host_rdata = cmd_invalid ? RESULT_CODE : '0;

    assert_legal_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |-> op_legal)
        else $error("command handed off with an unmapped opcode");

    assert_fifo_off_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pace_busy |-> !fifo_en)
        else $error("FIFO enabled during byte processing");

    assert_no_handoff_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_invalid |-> !cmd_valid)
        else $error("invalid command handed downstream");

endmodule

// File: tb/cmd_handshake_seq_test.sv
module cmd_handshake_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic [7:0]  host_rdata;
    logic        rqm, dio, exec_done = 1'b0;
    logic        cmd_valid, cmd_invalid, fifo_en;
    logic [3:0]  cmd_nbytes;
    logic [71:0] cmd_bytes;

    int checks = 0;
    int errors = 0;
    int valid_seen = 0;
    bit finished = 0;

    always #10 clk = ~clk;

    cmd_handshake_seq uut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .rqm(rqm), .dio(dio),
        .exec_done(exec_done), .cmd_valid(cmd_valid), .cmd_invalid(cmd_invalid),
        .cmd_nbytes(cmd_nbytes), .cmd_bytes(cmd_bytes), .fifo_en(fifo_en)
    );

    always @(negedge clk) if (rst_n && cmd_valid) valid_seen++;

    function automatic int exp_np(input logic [7:0] op);
        case (op)
            8'h08: return 0;
            8'h04, 8'h07, 8'h0A: return 1;
            8'h03, 8'h0F: return 2;
            8'h13: return 3;
            8'h0D: return 5;
            8'h05, 8'h06: return 8;
            default: return -1;
        endcase
    endfunction

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // One-cycle write strobe; returns at the falling edge after the accepting edge.
    task automatic push(input logic [7:0] b);
        @(negedge clk); host_wr = 1'b1; host_wdata = b;
        @(negedge clk); host_wr = 1'b0;
    endtask

    task automatic finish_exec(input string req);
        @(negedge clk); exec_done = 1'b1;
        @(negedge clk); exec_done = 1'b0;
        chk(req, "rqm after exec_done", rqm, 1);
        chk(req, "fifo_en after exec_done", fifo_en, 0);
        chk(req, "dio after exec_done", dio, 0);
    endtask

    // Full legal command: opcode plus its parameters, with per-byte timing checks.
    task automatic run_cmd(input logic [7:0] op, input logic [63:0] prm);
        int np = exp_np(op);
        push(op);
        chk("R3", "rqm edge1", rqm, 0);
        @(negedge clk); chk("R3", "rqm edge2", rqm, 0);
        @(negedge clk);
        for (int k = 0; k < np; k++) begin
            chk("R3", "rqm rearmed", rqm, 1);
            chk("R5", "no early valid", cmd_valid, 0);
            chk("R6", "fifo off in command phase", fifo_en, 0);
            push(prm[8*k +: 8]);
            chk("R3", "rqm edge1 param", rqm, 0);
            @(negedge clk); chk("R3", "rqm edge2 param", rqm, 0);
            @(negedge clk);
        end
        chk("R5", "cmd_valid", cmd_valid, 1);
        chk("R5", "rqm low at hand-off", rqm, 0);
        chk("R6", "fifo_en at hand-off", fifo_en, 1);
        chk("R4", "byte count", cmd_nbytes, np + 1);
        chk("R5", "opcode slot", cmd_bytes[7:0], op);
        for (int k = 0; k < np; k++)
            chk("R5", "param slot", cmd_bytes[8*(k+1) +: 8], prm[8*k +: 8]);
        @(negedge clk);
        chk("R5", "pulse one cycle", cmd_valid, 0);
        chk("R5", "rqm stays low", rqm, 0);
        chk("R6", "fifo stays on", fifo_en, 1);
        finish_exec("R9");
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rqm", rqm, 1);
        chk("R1", "dio", dio, 0);
        chk("R1", "fifo_en", fifo_en, 0);
        chk("R1", "cmd_valid", cmd_valid, 0);
        chk("R1", "cmd_invalid", cmd_invalid, 0);
        chk("R1", "host_rdata", host_rdata, 0);
    endtask

    task automatic t_table();
        logic [7:0] ops [10] = '{8'h08, 8'h04, 8'h07, 8'h0A, 8'h03,
                                 8'h0F, 8'h13, 8'h0D, 8'h05, 8'h06};
        for (int i = 0; i < 10; i++)
            run_cmd(ops[i], 64'hF1E2_D3C4_B5A6_9788 ^ {8{8'(i * 17)}});
    endtask

    task automatic t_ignored();
        // R2: write during the processing window is dropped.
        push(8'h0F);
        host_wr = 1'b1; host_wdata = 8'hEE;
        @(negedge clk); host_wr = 1'b0;
        chk("R2", "rqm still low", rqm, 0);
        @(negedge clk); chk("R2", "rqm rearm unchanged", rqm, 1);
        push(8'h11); @(negedge clk); @(negedge clk);
        chk("R2", "rqm for second param", rqm, 1);
        push(8'h22); @(negedge clk); @(negedge clk);
        chk("R2", "valid after real params", cmd_valid, 1);
        chk("R2", "count ignores stray", cmd_nbytes, 3);
        chk("R2", "slot1", cmd_bytes[15:8], 8'h11);
        chk("R2", "slot2", cmd_bytes[23:16], 8'h22);
        // R2: write during the execution phase is dropped.
        push(8'h55); @(negedge clk);
        chk("R2", "rqm low in exec", rqm, 0);
        chk("R2", "fifo on in exec", fifo_en, 1);
        chk("R2", "count unchanged", cmd_nbytes, 3);
        chk("R2", "slot1 unchanged", cmd_bytes[15:8], 8'h11);
        chk("R2", "slot3 empty", cmd_bytes[31:24], 0);
        finish_exec("R9");
        // R8: read in the command phase is ignored.
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        chk("R8", "rqm after stray read", rqm, 1);
        chk("R8", "dio after stray read", dio, 0);
        // R9: exec_done outside the execution phase is ignored.
        @(negedge clk); exec_done = 1'b1;
        @(negedge clk); exec_done = 1'b0;
        chk("R9", "rqm after stray done", rqm, 1);
        push(8'h08); @(negedge clk); @(negedge clk);
        chk("R9", "zero-param valid", cmd_valid, 1);
        chk("R9", "zero-param count", cmd_nbytes, 1);
        finish_exec("R9");
    endtask

    task automatic t_invalid();
        int base = valid_seen;
        push(8'hFF);
        chk("R7", "rqm edge1", rqm, 0);
        @(negedge clk);
        chk("R7", "dio edge2", dio, 0);
        chk("R7", "invalid edge2", cmd_invalid, 0);
        @(negedge clk);
        chk("R7", "rqm", rqm, 1);
        chk("R7", "dio", dio, 1);
        chk("R7", "cmd_invalid", cmd_invalid, 1);
        chk("R7", "host_rdata", host_rdata, 8'h80);
        chk("R6", "fifo off in result", fifo_en, 0);
        push(8'h03); @(negedge clk); @(negedge clk);
        chk("R2", "write ignored when dio=1", dio, 1);
        chk("R2", "rqm kept when dio=1", rqm, 1);
        chk("R7", "no hand-off", valid_seen, base);
        @(negedge clk); host_rd = 1'b1;
        @(negedge clk); host_rd = 1'b0;
        chk("R8", "rqm drops on read", rqm, 0);
        @(negedge clk); chk("R8", "rqm low edge2", rqm, 0);
        @(negedge clk);
        chk("R8", "rqm back", rqm, 1);
        chk("R8", "dio back", dio, 0);
        chk("R8", "invalid cleared", cmd_invalid, 0);
        chk("R8", "rdata cleared", host_rdata, 0);
        run_cmd(8'h04, 64'h5A);
    endtask

    initial begin
        t_reset();
        t_table();
        t_ignored();
        t_invalid();
        t_reset();
        run_cmd(8'h13, 64'h0302_01);
        finished = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule